// File: doc/BRIEF.md
# Dual-Edge 4-bit Event Counter

This block is a small event counter with a wrap flag and an interrupt request. Its count advances on one of three event sources, chosen by a select field. The first is any transition, rising or falling, of an asynchronous external clock pin. The second is a one-cycle overflow pulse from a neighbouring timer. The third is a one-cycle software strobe. When the count wraps from its top value back to zero, a sticky flag is set. A one-cycle carry pulse is also emitted, which a downstream 8-bit timer can count to extend the range to 12 bits.

A processor can load the count at any time and clears the flag by writing a one to the clear input. When the interrupt enable is high, the flag drives the interrupt request. If software loads the top value and selects the external source, the next pin transition sets the flag. The counter then serves as one more external interrupt line.

Top module: `evt_nibble_counter`

## Requirements
- R1: After reset the count is 0 and the flag, the carry pulse and the interrupt request are all low.
- R2: With select value 2'b01, each rising and each falling transition of `ext_clk` adds exactly one to the count, after a two-flop synchroniser.
- R3: With select value 2'b10, every system clock cycle in which `tmr_tick` is high adds one to the count on the next clock edge.
- R4: With select value 2'b11, every system clock cycle in which `sw_strobe` is high adds one to the count on the next clock edge.
- R5: Sources that are not selected are ignored, and select value 2'b00 holds the count unchanged.
- R6: An increment from 4'hF wraps the count to 0, sets the flag and raises `carry_out` for exactly one clock cycle.
- R7: `irq` is high exactly when the flag is set and `irq_en` is 1.
- R8: A count write (`cnt_we`) loads `cnt_wdata` on the next edge, overrides a coincident increment, and does not set the flag.
- R9: Writing 1 on `flag_clr` clears the flag, unless a wrap happens in the same cycle, in which case the flag stays set.
- R10: After 4'hF is preloaded, a single event of the selected source sets the flag.
- R11: Over a run of 16·N events starting from count 0, `carry_out` pulses exactly N times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | Asynchronous external event clock, both edges count |
| tmr_tick | input | 1 | One-cycle timer overflow pulse |
| sw_strobe | input | 1 | One-cycle software count strobe |
| src_sel | input | 2 | Event source: 00 none, 01 external, 10 timer, 11 software |
| cnt_we | input | 1 | Count write enable |
| cnt_wdata | input | CNT_W | Count write value |
| flag_clr | input | 1 | Write-one-to-clear for the overflow flag |
| irq_en | input | 1 | Overflow interrupt enable |
| count | output | CNT_W | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |
| carry_out | output | 1 | One-cycle wrap pulse for a cascaded timer |

## Verification
The assertions check the following on every cycle. A write always lands on the next edge. The count never moves while no source is selected. Each timer tick adds exactly one. The carry pulse never lasts two cycles. The flag can only rise together with a carry. A clear leaves the flag low unless a wrap happened at the same time. Only the bench scenarios can show that both edges of the asynchronous pin count after synchronisation, that preloading 4'hF turns one pin transition into an interrupt, and that a run of events yields the right number of carries for a cascaded timer.

// File: rtl/evt_nibble_counter.sv
module evt_nibble_counter #(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic             tmr_tick,
  input  logic             sw_strobe,
  input  logic [1:0]       src_sel,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             flag_clr,
  input  logic             irq_en,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             irq,
  output logic             carry_out
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [SYNC_STAGES-1:0] ext_sync;
  logic                   ext_prev;
  logic                   ext_edge;
  logic                   bump;
  logic                   wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sync <= '0;
      ext_prev <= 1'b0;
    end else begin
      ext_sync <= {ext_sync[SYNC_STAGES-2:0], ext_clk};
      ext_prev <= ext_sync[SYNC_STAGES-1];
    end
  end

  assign ext_edge = ext_sync[SYNC_STAGES-1] ^ ext_prev;

  always_comb begin
    case (src_sel)
      2'b01:   bump = ext_edge;
      2'b10:   bump = tmr_tick;
      2'b11:   bump = sw_strobe;
      default: bump = 1'b0;
    endcase
  end

  assign wrap = bump && !cnt_we && (count == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      ovf_flag  <= 1'b0;
      carry_out <= 1'b0;
    end else begin
      if (cnt_we)    count <= cnt_wdata;
      else if (bump) count <= count + CNT_ONE;
      if (wrap)          ovf_flag <= 1'b1;
      else if (flag_clr) ovf_flag <= 1'b0;
      carry_out <= wrap;
    end
  end

  assign irq = ovf_flag & irq_en;

endmodule

// File: rtl/evt_nibble_counter_chk.sv
module evt_nibble_counter_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_tick,
  input logic [1:0]       src_sel,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic             flag_clr,
  input logic             irq_en,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input logic             irq,
  input logic             carry_out
);

  // R8
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> count == $past(cnt_wdata));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b00 && !cnt_we) |=> $stable(count));

  // R3
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b10 && tmr_tick && !cnt_we) |=> count == CNT_W'($past(count) + 1'b1));

  // R6
  carry_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |=> !carry_out);

  // R6
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> carry_out);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> (!ovf_flag || carry_out));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

endmodule

bind evt_nibble_counter evt_nibble_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .src_sel(src_sel),
  .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .flag_clr(flag_clr), .irq_en(irq_en),
  .count(count), .ovf_flag(ovf_flag), .irq(irq), .carry_out(carry_out)
);

// File: tb/test_evt_nibble_counter.sv
module test_evt_nibble_counter;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 0, rst_n = 0;
  logic       ext_clk = 0, tmr_tick = 0, sw_strobe = 0;
  logic [1:0] src_sel = 0;
  logic       cnt_we = 0, flag_clr = 0, irq_en = 0;
  logic [3:0] cnt_wdata = 0;
  logic [3:0] count;
  logic       ovf_flag, irq, carry_out;
  int tests = 0, fails = 0;

  evt_nibble_counter i_evt_nibble_counter (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .tmr_tick(tmr_tick),
    .sw_strobe(sw_strobe), .src_sel(src_sel), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .flag_clr(flag_clr), .irq_en(irq_en),
    .count(count), .ovf_flag(ovf_flag), .irq(irq), .carry_out(carry_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(logic [3:0] v);
    @(negedge clk); cnt_we = 1; cnt_wdata = v;
    @(negedge clk); cnt_we = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic pulse_sw();
    @(negedge clk); sw_strobe = 1;
    @(negedge clk); sw_strobe = 0;
  endtask

  task automatic pulse_tmr();
    @(negedge clk); tmr_tick = 1;
    @(negedge clk); tmr_tick = 0;
  endtask

  task automatic toggle_ext();
    @(negedge clk); ext_clk = ~ext_clk;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 carry", carry_out, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_external();
    src_sel = 2'b01; load(0);
    for (int i = 1; i <= 6; i++) begin
      toggle_ext();
      chk("R2 edge count", count, i);
    end
    pulse_sw(); pulse_tmr();
    chk("R5 others ignored in ext mode", count, 6);
  endtask

  task automatic t_timer_sw();
    src_sel = 2'b10; load(3);
    pulse_tmr(); chk("R3 timer tick", count, 4);
    pulse_sw();  chk("R5 strobe ignored in timer mode", count, 4);
    src_sel = 2'b11;
    pulse_sw();  chk("R4 strobe", count, 5);
    pulse_tmr(); chk("R5 tick ignored in sw mode", count, 5);
  endtask

  task automatic t_idle();
    src_sel = 2'b00; load(7);
    pulse_sw(); pulse_tmr(); toggle_ext(); toggle_ext();
    chk("R5 idle hold", count, 7);
  endtask

  task automatic t_wrap_irq();
    src_sel = 2'b11; irq_en = 0; load(4'hE); clear_flag();
    pulse_sw(); chk("R6 no flag before wrap", ovf_flag, 0);
    @(negedge clk); sw_strobe = 1;
    @(negedge clk); sw_strobe = 0;
    chk("R6 wrap count", count, 0);
    chk("R6 flag set", ovf_flag, 1);
    chk("R6 carry high", carry_out, 1);
    chk("R7 irq masked", irq, 0);
    @(negedge clk);
    chk("R6 carry one cycle", carry_out, 0);
    irq_en = 1; #1;
    chk("R7 irq enabled", irq, 1);
    clear_flag();
    chk("R9 flag cleared", ovf_flag, 0);
    chk("R7 irq after clear", irq, 0);
    irq_en = 0;
  endtask

  task automatic t_write_prio();
    src_sel = 2'b11; load(5); clear_flag();
    @(negedge clk); cnt_we = 1; cnt_wdata = 9; sw_strobe = 1;
    @(negedge clk); cnt_we = 0; sw_strobe = 0;
    chk("R8 write wins", count, 9);
    load(4'hF);
    @(negedge clk); cnt_we = 1; cnt_wdata = 4'hF; sw_strobe = 1;
    @(negedge clk); cnt_we = 0; sw_strobe = 0;
    chk("R8 write at max", count, 15);
    chk("R8 no flag", ovf_flag, 0);
  endtask

  task automatic t_clear_race();
    src_sel = 2'b11; load(4'hF); pulse_sw();
    chk("R9 flag preset", ovf_flag, 1);
    load(4'hF);
    @(negedge clk); flag_clr = 1; sw_strobe = 1;
    @(negedge clk); flag_clr = 0; sw_strobe = 0;
    chk("R9 wrap beats clear", ovf_flag, 1);
    clear_flag();
    chk("R9 plain clear", ovf_flag, 0);
  endtask

  task automatic t_ext_irq();
    src_sel = 2'b00; load(4'hF); clear_flag();
    src_sel = 2'b01; irq_en = 1;
    repeat (3) @(negedge clk);
    chk("R10 no irq before edge", irq, 0);
    toggle_ext();
    chk("R10 one edge raises flag", ovf_flag, 1);
    chk("R10 irq", irq, 1);
    irq_en = 0; clear_flag();
  endtask

  task automatic t_cascade();
    int carries = 0;
    src_sel = 2'b10; load(0); clear_flag();
    @(negedge clk); tmr_tick = 1;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (carry_out) carries++;
    end
    tmr_tick = 0;
    chk("R11 carries", carries, 3);
    chk("R11 count end", count, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_external();
    t_timer_sw();
    t_idle();
    t_wrap_irq();
    t_write_prio();
    t_clear_race();
    t_ext_irq();
    t_cascade();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule